// File: doc/BRIEF.md
# Peripheral Slot Address Decoder

This block sits between a 16-bit CPU bus and a seven-slot peripheral expansion bus. It watches every access that falls in the $C000-$CFFF page group and turns it into one of four kinds of select. A low slice of that space belongs to the on-chip soft switches and is only flagged. The upper half of page $C0 gives each slot sixteen device I/O bytes. Pages $C1-$C7 give each slot a 256-byte ROM window. The 2 KB area at $C800-$CFFF is a shared expansion ROM window, served by whichever slot last touched its own ROM page.

An ownership register records which slot, if any, holds the expansion window. Touching $CFFF gives the window up. When a card sits in the auxiliary slot, it replaces slot 3 in the expansion window, and slot 3's own expansion ROM can then never be reached. Read data is taken from the selected slot's data lane. Space that no card backs reads as $FF. Selects are combinational from the address and strobes. Ownership changes on the clock edge at which the access strobe is high.

Top module: `exp_slot_decode`

## Requirements
- R1: An access (rd_en or wr_en high) to $C000-$C08F raises int_sel and no slot select. Read data is $FF.
- R2: An access to $C090-$C0FF raises dev_sel bit (s-1), where s = addr[6:4]. On a read the data is slot s's lane if slot_fitted bit (s-1) is set, and $FF otherwise.
- R3: An access to $Cs00-$CsFF with s in 1..7 (s = addr[10:8]) raises rom_sel bit (s-1). On a read the data is slot s's lane if slot s is fitted, and $FF otherwise.
- R4: An access to slot s's ROM page makes s the owner of the expansion window from the next clock edge. This holds whether the slot is fitted or not.
- R5: An access to $CFFF leaves the window with no owner from the next clock edge. That same access is still served by the current owner.
- R6: An access to $C800-$CFFF with no owner, or with an owner whose xrom_fitted bit is clear, raises no expansion select. A read there returns $FF.
- R7: When aux_present is high and slot 3 owns the window, an expansion access raises aux_xsel and returns aux_rdata. xrom_sel bit 2 stays low. When aux_present is low, slot 3 behaves like any other slot.
- R8: Reset (rst_n low) clears expansion window ownership.
- R9: With rd_en and wr_en both low, every select is low, the read data is $FF, and ownership does not change.
- R10: Addresses outside $C000-$CFFF raise no select and return $FF.
- R11: At most one of int_sel, dev_sel, rom_sel, xrom_sel and aux_xsel is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| slot_rdata | input | 56 | Read data lanes; bits [8k+7:8k] come from slot k+1 |
| slot_fitted | input | 7 | Bit k set when slot k+1 holds a card with I/O and ROM |
| xrom_fitted | input | 7 | Bit k set when slot k+1's card carries an expansion ROM |
| aux_present | input | 1 | An auxiliary-slot card is installed |
| aux_rdata | input | 8 | Expansion ROM data from the auxiliary-slot card |
| int_sel | output | 1 | Internal soft-switch access |
| dev_sel | output | 7 | One-hot device I/O select; bit k is slot k+1 |
| rom_sel | output | 7 | One-hot slot ROM page select |
| xrom_sel | output | 7 | One-hot expansion ROM select |
| aux_xsel | output | 1 | Auxiliary card expansion ROM select |
| rdata | output | 8 | Read data returned to the CPU |

## Verification
The bench targets the edges of the page-$C0 split. $C08F must stay internal and $C090 must reach slot 1; an off-by-one there would select a slot on a soft-switch access. It then follows ownership through sequences of events: a ROM touch on an unfitted slot, an owner with no expansion ROM, a $CFFF read that must still return the old owner's byte, an idle cycle parked on a ROM address, and a reset while a slot owns the window. A design that updated ownership without a strobe, or released the window before serving the $CFFF access, would return the wrong lane on the following $C800 read. The auxiliary card is switched in and out while slot 3 owns the window, so a decoder that leaked slot 3's expansion select beside the auxiliary card would fail both the data compare and the one-select rule.

// File: rtl/exp_pkg.sv
package exp_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_INT,
        RG_DEV,
        RG_ROM,
        RG_XROM
    } region_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] slot;
    } owner_t;

endpackage

// File: rtl/exp_region_dec.sv
module exp_region_dec
    import exp_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic [2:0]    slot,
    output logic          is_release
);

    localparam logic [3:0] IO_NIBBLE = 4'hC;
    localparam logic [AW-1:0] RELEASE_ADDR = AW'(16'hCFFF);

    always_comb begin
        region = RG_NONE;
        slot   = 3'd0;
        if (addr[15:12] == IO_NIBBLE) begin
            if (addr[11]) begin
                region = RG_XROM;
            end else if (addr[10:8] != 3'd0) begin
                region = RG_ROM;
                slot   = addr[10:8];
            end else if (addr[7] && (addr[6:4] != 3'd0)) begin
                region = RG_DEV;
                slot   = addr[6:4];
            end else begin
                region = RG_INT;
            end
        end
        is_release = (addr == RELEASE_ADDR);
    end

endmodule

// File: rtl/exp_owner_track.sv
module exp_owner_track
    import exp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    acc,
    input  region_e region,
    input  logic [2:0] slot,
    input  logic    is_release,
    output owner_t  owner
);

    owner_t owner_d, owner_q;

    always_comb begin
        owner_d = owner_q;
        if (acc) begin
            if (region == RG_ROM) begin
                owner_d.valid = 1'b1;
                owner_d.slot  = slot;
            end else if (is_release) begin
                owner_d.valid = 1'b0;
                owner_d.slot  = 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= '0;
        end else begin
            owner_q <= owner_d;
        end
    end

    assign owner = owner_q;

endmodule

// File: rtl/exp_sel_mux.sv
module exp_sel_mux
    import exp_pkg::*;
#(
    parameter int          NSLOT    = 7,
    parameter int          DW       = 8,
    parameter int          AUX_SLOT = 3,
    parameter logic [DW-1:0] FILL   = '1
) (
    input  logic              acc,
    input  region_e           region,
    input  logic [2:0]        slot,
    input  owner_t            owner,
    input  logic [NSLOT*DW-1:0] slot_rdata,
    input  logic [NSLOT-1:0]  slot_fitted,
    input  logic [NSLOT-1:0]  xrom_fitted,
    input  logic              aux_present,
    input  logic [DW-1:0]     aux_rdata,
    output logic              int_sel,
    output logic [NSLOT-1:0]  dev_sel,
    output logic [NSLOT-1:0]  rom_sel,
    output logic [NSLOT-1:0]  xrom_sel,
    output logic              aux_xsel,
    output logic [DW-1:0]     rdata
);

    localparam logic [2:0] AUX_NUM = 3'(AUX_SLOT);

    logic xacc;
    assign xacc     = acc && (region == RG_XROM) && owner.valid;
    assign int_sel  = acc && (region == RG_INT);
    assign aux_xsel = xacc && aux_present && (owner.slot == AUX_NUM);

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        localparam logic [2:0] SN     = 3'(k + 1);
        localparam bit         IS_AUX = ((k + 1) == AUX_SLOT);
        logic aux_shadow;
        assign aux_shadow  = IS_AUX && aux_present;
        assign dev_sel[k]  = acc && (region == RG_DEV) && (slot == SN);
        assign rom_sel[k]  = acc && (region == RG_ROM) && (slot == SN);
        assign xrom_sel[k] = xacc && (owner.slot == SN) && xrom_fitted[k] && !aux_shadow;
    end

    always_comb begin
        rdata = FILL;
        for (int k = 0; k < NSLOT; k++) begin
            if (((dev_sel[k] || rom_sel[k]) && slot_fitted[k]) || xrom_sel[k]) begin
                rdata = slot_rdata[k*DW +: DW];
            end
        end
        if (aux_xsel) begin
            rdata = aux_rdata;
        end
    end

endmodule

// File: rtl/exp_slot_decode.sv
module exp_slot_decode
    import exp_pkg::*;
#(
    parameter int NSLOT    = 7,
    parameter int DW       = 8,
    parameter int AUX_SLOT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [NSLOT*DW-1:0] slot_rdata,
    input  logic [NSLOT-1:0]  slot_fitted,
    input  logic [NSLOT-1:0]  xrom_fitted,
    input  logic              aux_present,
    input  logic [DW-1:0]     aux_rdata,
    output logic              int_sel,
    output logic [NSLOT-1:0]  dev_sel,
    output logic [NSLOT-1:0]  rom_sel,
    output logic [NSLOT-1:0]  xrom_sel,
    output logic              aux_xsel,
    output logic [DW-1:0]     rdata
);

    logic       acc;
    region_e    region;
    logic [2:0] slot;
    logic       is_release;
    owner_t     owner_q;

    assign acc = rd_en || wr_en;

    exp_region_dec #(.AW(16)) u_dec (
        .addr       (addr),
        .region     (region),
        .slot       (slot),
        .is_release (is_release)
    );

    exp_owner_track u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .region     (region),
        .slot       (slot),
        .is_release (is_release),
        .owner      (owner_q)
    );

    exp_sel_mux #(
        .NSLOT    (NSLOT),
        .DW       (DW),
        .AUX_SLOT (AUX_SLOT),
        .FILL     ({DW{1'b1}})
    ) u_mux (
        .acc         (acc),
        .region      (region),
        .slot        (slot),
        .owner       (owner_q),
        .slot_rdata  (slot_rdata),
        .slot_fitted (slot_fitted),
        .xrom_fitted (xrom_fitted),
        .aux_present (aux_present),
        .aux_rdata   (aux_rdata),
        .int_sel     (int_sel),
        .dev_sel     (dev_sel),
        .rom_sel     (rom_sel),
        .xrom_sel    (xrom_sel),
        .aux_xsel    (aux_xsel),
        .rdata       (rdata)
    );

endmodule

// File: rtl/exp_slot_decode_chk.sv
module exp_slot_decode_chk #(
    parameter int NSLOT = 7,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      addr,
    input logic             rd_en,
    input logic             wr_en,
    input logic             aux_present,
    input logic             int_sel,
    input logic [NSLOT-1:0] dev_sel,
    input logic [NSLOT-1:0] rom_sel,
    input logic [NSLOT-1:0] xrom_sel,
    input logic             aux_xsel,
    input logic [DW-1:0]    rdata,
    input logic             own_valid,
    input logic [2:0]       own_slot
);

    logic acc;
    logic any_slot_sel;
    assign acc          = rd_en || wr_en;
    assign any_slot_sel = (|dev_sel) || (|rom_sel) || (|xrom_sel) || aux_xsel;

    p_internal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && addr[15:8] == 8'hC0 && addr[7:4] < 4'h9) |-> (int_sel && !any_slot_sel));

    p_rom_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && addr[15:11] == 5'b11000 && addr[10:8] != 3'd0)
        |=> (own_valid && own_slot == $past(addr[10:8])));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && addr == 16'hCFFF) |=> !own_valid);

    p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_slot_sel) |-> (rdata == {DW{1'b1}}));

    p_aux_r7: assert property (@(posedge clk) disable iff (!rst_n)
        aux_present |-> !xrom_sel[2]);

    p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !own_valid);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(own_valid) && $stable(own_slot)));

    p_idle_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> (!any_slot_sel && !int_sel));

    p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:12] != 4'hC) |-> (!any_slot_sel && !int_sel));

    p_one_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_sel, dev_sel, rom_sel, xrom_sel, aux_xsel}));

endmodule

bind exp_slot_decode exp_slot_decode_chk #(.NSLOT(NSLOT), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .aux_present (aux_present),
    .int_sel     (int_sel),
    .dev_sel     (dev_sel),
    .rom_sel     (rom_sel),
    .xrom_sel    (xrom_sel),
    .aux_xsel    (aux_xsel),
    .rdata       (rdata),
    .own_valid   (owner_q.valid),
    .own_slot    (owner_q.slot)
);

// File: tb/exp_slot_decode_tb.sv
`timescale 1ns/1ps
module exp_slot_decode_tb;

    localparam int NSLOT = 7;
    localparam int DW    = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic [15:0]       addr;
    logic              rd_en, wr_en;
    logic [NSLOT*DW-1:0] slot_rdata;
    logic [NSLOT-1:0]  slot_fitted, xrom_fitted;
    logic              aux_present;
    logic [DW-1:0]     aux_rdata;
    logic              int_sel, aux_xsel;
    logic [NSLOT-1:0]  dev_sel, rom_sel, xrom_sel;
    logic [DW-1:0]     rdata;

    exp_slot_decode u_dut (
        .clk, .rst_n, .addr, .rd_en, .wr_en, .slot_rdata, .slot_fitted,
        .xrom_fitted, .aux_present, .aux_rdata, .int_sel, .dev_sel,
        .rom_sel, .xrom_sel, .aux_xsel, .rdata
    );

    int n_checks = 0;
    int n_fail   = 0;
    int model_own = 0;   // 0 = nobody owns the expansion window
    bit done = 0;

    function automatic logic [7:0] lane(int s);
        return {4'hA, 4'(s)};
    endfunction

    task automatic step(input logic [15:0] a, input logic r, input logic w, input string tag);
        logic [6:0] e_dev, e_rom, e_x;
        logic e_int, e_aux;
        logic [7:0] e_d;
        logic [30:0] got, exp;
        bit acc;
        int s;
        @(negedge clk);
        addr = a; rd_en = r; wr_en = w;
        #1;
        acc = r || w;
        e_dev = '0; e_rom = '0; e_x = '0; e_int = 0; e_aux = 0; e_d = 8'hFF;
        if (acc && a[15:12] == 4'hC) begin
            if (a[11]) begin
                if (model_own != 0) begin
                    if (model_own == 3 && aux_present) begin
                        e_aux = 1; e_d = aux_rdata;
                    end else if (xrom_fitted[model_own-1]) begin
                        e_x[model_own-1] = 1; e_d = lane(model_own);
                    end
                end
            end else if (a[10:8] != 0) begin
                s = int'(a[10:8]);
                e_rom[s-1] = 1;
                if (slot_fitted[s-1]) e_d = lane(s);
            end else if (a[7:0] >= 8'h90) begin
                s = int'(a[6:4]);
                e_dev[s-1] = 1;
                if (slot_fitted[s-1]) e_d = lane(s);
            end else begin
                e_int = 1;
            end
        end
        got = {int_sel, dev_sel, rom_sel, xrom_sel, aux_xsel, rdata};
        exp = {e_int, e_dev, e_rom, e_x, e_aux, e_d};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h rd=%0b wr=%0b actual=%h expected=%h", tag, a, r, w, got, exp);
        end
        n_checks++;
        if ($countones({int_sel, dev_sel, rom_sel, xrom_sel, aux_xsel}) > 1) begin
            n_fail++;
            $display("FAIL R11 addr=%h actual=%h expected=at most one select", a, got[30:8]);
        end
        @(posedge clk);
        if (rst_n && acc && a[15:12] == 4'hC && !a[11] && a[10:8] != 0)
            model_own = int'(a[10:8]);
        else if (rst_n && acc && a == 16'hCFFF)
            model_own = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; rd_en = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        model_own = 0;
        rst_n = 1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; addr = '0; rd_en = 0; wr_en = 0;
        for (int k = 0; k < NSLOT; k++) slot_rdata[k*DW +: DW] = {4'hA, 4'(k + 1)};
        slot_fitted = 7'b1110111;   // slot 4 empty
        xrom_fitted = 7'b0010101;   // slots 1, 3, 5 carry expansion ROM
        aux_present = 0;
        aux_rdata   = 8'h5A;
        do_reset();

        // R8: no owner after reset
        step(16'hC800, 1, 0, "R8");
        // R10: outside the I/O page group
        step(16'h0000, 1, 0, "R10");
        step(16'hBFFF, 1, 0, "R10");
        step(16'hD000, 1, 0, "R10");
        step(16'hFFFF, 0, 1, "R10");
        // R1: internal soft switches, including the $C08F edge
        step(16'hC000, 1, 0, "R1");
        step(16'hC05F, 0, 1, "R1");
        step(16'hC08F, 1, 0, "R1");
        // R2: device I/O for every slot, slot 4 empty
        for (int s = 1; s <= 7; s++) step(16'hC080 + 16'(s * 16) + 16'h5, 1, 0, "R2");
        step(16'hC090, 0, 1, "R2");
        // R3: ROM pages, slot 4 empty
        for (int s = 1; s <= 7; s++) step(16'hC000 + 16'(s * 256) + 16'h42, 1, 0, "R3");
        // R6: owner 7 has no expansion ROM
        step(16'hC800, 1, 0, "R6");
        step(16'hC200, 1, 0, "R6");
        step(16'hC9AB, 1, 0, "R6");
        // R4: ownership moves with ROM page touches, reads and writes
        step(16'hC105, 1, 0, "R4");
        step(16'hCA00, 1, 0, "R4");
        step(16'hC5FF, 0, 1, "R4");
        step(16'hC800, 1, 0, "R4");
        step(16'hC400, 1, 0, "R4");   // unfitted slot still takes the window
        step(16'hC800, 1, 0, "R4");
        step(16'hC510, 1, 0, "R4");
        // R5: $CFFF served by owner, then released
        step(16'hCFFF, 1, 0, "R5");
        step(16'hC800, 1, 0, "R5");
        step(16'hCFFF, 1, 0, "R5");
        // R7: slot 3 with and without the auxiliary card
        step(16'hC310, 1, 0, "R7");
        step(16'hC900, 1, 0, "R7");
        aux_present = 1;
        step(16'hC900, 1, 0, "R7");
        step(16'hCC33, 0, 1, "R7");
        step(16'hC0B0, 1, 0, "R7");
        step(16'hC100, 1, 0, "R7");
        step(16'hC900, 1, 0, "R7");
        step(16'hC300, 1, 0, "R7");
        // R9: idle cycle on a ROM page and on $CFFF leaves owner alone
        step(16'hC100, 0, 0, "R9");
        step(16'hCFFF, 0, 0, "R9");
        step(16'hC800, 1, 0, "R9");
        aux_present = 0;
        step(16'hC800, 1, 0, "R9");
        // R8: reset while a slot owns the window
        step(16'hC500, 1, 0, "R8");
        do_reset();
        step(16'hC800, 1, 0, "R8");
        // R11: sweep across the whole page group
        step(16'hC700, 1, 0, "R11");
        for (int a = 16'hBF80; a < 16'hD080; a += 16'h53) step(16'(a), 1, 0, "R11");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule